// File: doc/BRIEF.md
# Scratchpad Transfer Unit

This unit moves bytes between a processor's general register file and four scratchpad banks that share the register file's shape: 30 registers of four byte lanes each. Every bank holds its bytes at the same register index and lane as the register file, so a transfer is a run of byte copies (or swaps) between identically positioned bytes. One command gives an operation, a device ID, a starting register, a starting lane and a byte count. The unit then walks the run one byte per cycle and pulses a completion flag.

The register file stays outside the unit. The unit presents a byte address (register index and lane) to it, samples the addressed byte combinationally, and asks for a write of one byte when the operation requires it. The banks are internal. Their contents can be seen only by bringing them back into the register file with a read-in.

Two reserved device IDs turn a read-in into a constant fill of the target bytes. Any command that cannot be carried out finishes at once with an error flag and moves no data. This covers an unknown device, a fill ID used with a write-out or an exchange, the reserved operation code, and a run that passes the end of the register file.

Top module: `xfr_scratch_unit`

## Requirements
- R1: A start accepted while idle with a valid command of N bytes (N > 0), sampled at clock edge E, writes its bytes at edges E+1 through E+N. `done_o` is high for exactly one cycle, the cycle that follows edge E+N.
- R2: Byte k of a run sits at byte position P = 4*reg_i + lane_i + k. Here register = P/4 and lane = P mod 4, so the lane steps 0,1,2,3 and then wraps to 0 of the next register. The unit presents that byte's address on `rf_idx_o` and `rf_lane_o`.
- R3: Read-in (op 0) with device ID 10, 11, 12 or 14 (bank 0, bank 1, bank 2, peer bank) copies each bank byte into the register byte at the same position.
- R4: Write-out (op 1) copies each register byte into the selected bank at the same position and never writes the register file.
- R5: Exchange (op 2) swaps each register byte with the bank byte at the same position. Both old values are taken before either is replaced.
- R6: Read-in with device ID 254 writes 0xFF into every target register byte, and device ID 255 writes 0x00. No bank changes.
- R7: These commands assert `err_o` together with `done_o` in the cycle after the start edge, with no register or bank write: a device ID outside {10,11,12,14,254,255}, ID 254 or 255 with op 1 or op 2, and op 3.
- R8: A command with 4*reg_i + lane_i + len_i > 120 fails as in R7.
- R9: A valid command with len_i = 0 pulses `done_o` without `err_o` in the cycle after the start edge and writes nothing.
- R10: A start pulse while a transfer is in progress is ignored. The running transfer finishes unchanged and no second transfer follows.
- R11: While reset is asserted, `done_o`, `err_o` and `rf_we_o` are low. The asynchronous reset is released inside the unit two clock edges after `rst_n` rises.
- R12: The four banks are independent. A write-out or exchange on one bank leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command strobe, one cycle |
| op_i | input | 2 | 0 read-in, 1 write-out, 2 exchange, 3 reserved |
| dev_i | input | 8 | Device ID of the bank or fill constant |
| reg_i | input | 5 | Starting register index |
| lane_i | input | 2 | Starting byte lane |
| len_i | input | 7 | Number of bytes |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Command rejected; high with `done_o` |
| rf_idx_o | output | 5 | Register index of the current byte |
| rf_lane_o | output | 2 | Byte lane of the current byte |
| rf_we_o | output | 1 | Register byte write enable |
| rf_wdata_o | output | 8 | Byte written into the register file |
| rf_rdata_i | input | 8 | Register byte at `rf_idx_o`/`rf_lane_o` |

## Verification
A cursor that steps wrongly shows at the register file as soon as the transfer ends. It shows as a byte written at a shifted position or a byte missed at a lane wrap, and as a `done_o` pulse that comes early or late against the requested length. A bank written at the wrong position or in the wrong bank stays hidden until a later read-in of that bank. The bench therefore reads every bank back in full at the end. A latched mode that is wrong shows in the first byte of the run, as a constant, a swap or a missing write in the register file.

// File: rtl/xfr_pkg.sv
package xfr_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SWAP  = 2'd2,
    OP_RSVD  = 2'd3
  } xfr_op_e;

  typedef enum logic [1:0] {
    ACT_READ,
    ACT_WRITE,
    ACT_SWAP,
    ACT_FILL
  } xfr_act_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } xfr_state_e;

  localparam int unsigned DEV_W     = 8;
  localparam int unsigned NUM_BANKS = 4;
  localparam int unsigned BANK_W    = $clog2(NUM_BANKS);

  // Device IDs of bank 0, bank 1, bank 2 and the peer bank, by bank index.
  localparam logic [DEV_W-1:0] BANK_DEV_ID [NUM_BANKS] = '{8'd10, 8'd11, 8'd12, 8'd14};
  localparam logic [DEV_W-1:0] DEV_FILL_ONES  = 8'd254;
  localparam logic [DEV_W-1:0] DEV_FILL_ZEROS = 8'd255;

  typedef struct packed {
    xfr_act_e          act;
    logic [BANK_W-1:0] bank;
    logic [7:0]        fill;
  } xfr_mode_t;

endpackage

// File: rtl/xfr_dev_decode.sv
module xfr_dev_decode
  import xfr_pkg::*;
#(
  parameter int unsigned PTR_W     = 7,
  parameter int unsigned LEN_W     = 7,
  parameter int unsigned NUM_BYTES = 120
) (
  input  xfr_op_e          op_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [LEN_W-1:0] len_i,
  output xfr_mode_t        mode_o,
  output logic             bad_o
);

  localparam int unsigned SUM_W = ((PTR_W > LEN_W) ? PTR_W : LEN_W) + 1;

  logic             bank_hit;
  logic             is_fill;
  logic             overrun;
  logic [SUM_W-1:0] end_ptr;

  always_comb begin
    bank_hit    = 1'b0;
    mode_o.bank = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      if (dev_i == BANK_DEV_ID[b]) begin
        bank_hit    = 1'b1;
        mode_o.bank = BANK_W'(b);
      end
    end
    is_fill     = (dev_i == DEV_FILL_ONES) || (dev_i == DEV_FILL_ZEROS);
    mode_o.fill = (dev_i == DEV_FILL_ONES) ? 8'hFF : 8'h00;

    end_ptr = SUM_W'(ptr_i) + SUM_W'(len_i);
    overrun = end_ptr > SUM_W'(NUM_BYTES);

    unique case (op_i)
      OP_READ:  mode_o.act = is_fill ? ACT_FILL : ACT_READ;
      OP_WRITE: mode_o.act = ACT_WRITE;
      OP_SWAP:  mode_o.act = ACT_SWAP;
      default:  mode_o.act = ACT_READ;
    endcase

    bad_o = overrun
         || (op_i == OP_RSVD)
         || !(bank_hit || is_fill)
         || (is_fill && (op_i != OP_READ));
  end

endmodule

// File: rtl/xfr_cursor.sv
module xfr_cursor
  import xfr_pkg::*;
#(
  parameter int unsigned PTR_W = 7,
  parameter int unsigned LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             bad_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             accept_o,
  output logic             active_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             done_o,
  output logic             err_o
);

  xfr_state_e       state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [LEN_W-1:0] remain_q, remain_d;
  logic             err_q, err_d;
  logic             step_en;

  // Next-state process
  always_comb begin
    state_d  = state_q;
    ptr_d    = ptr_q;
    remain_d = remain_q;
    err_d    = err_q;
    step_en  = 1'b0;
    accept_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          err_d    = bad_i;
          if (bad_i || (len_i == '0)) begin
            state_d = ST_FIN;
          end else begin
            state_d  = ST_RUN;
            ptr_d    = ptr_i;
            remain_d = len_i;
            step_en  = 1'b1;
          end
        end
      end
      ST_RUN: begin
        ptr_d    = ptr_q + PTR_W'(1);
        remain_d = remain_q - LEN_W'(1);
        step_en  = 1'b1;
        if (remain_q == LEN_W'(1)) state_d = ST_FIN;
      end
      ST_FIN: begin
        state_d = ST_IDLE;
        err_d   = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process: control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  // Register process: byte cursor, clock-enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      remain_q <= '0;
    end else if (step_en) begin
      ptr_q    <= ptr_d;
      remain_q <= remain_d;
    end
  end

  assign active_o = (state_q == ST_RUN);
  assign done_o   = (state_q == ST_FIN);
  assign err_o    = done_o && err_q;
  assign ptr_o    = ptr_q;

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_last_byte_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && (remain_q == LEN_W'(1))) |=> done_o);

  assert_lane_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && (remain_q > LEN_W'(1))) |=> (ptr_q == PTR_W'($past(ptr_q) + 1'b1)));

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && start_i && (remain_q > LEN_W'(1))) |=> (active_o && !done_o));

endmodule

// File: rtl/xfr_bank_store.sv
module xfr_bank_store
  import xfr_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 120,
  parameter int unsigned PTR_W     = 7
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);

  logic [7:0] rd_bank [NUM_BANKS];

  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
    logic [7:0] mem_q [NUM_BYTES];
    logic       bank_we;

    assign bank_we = we_i && (bank_i == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (bank_we) mem_q[ptr_i] <= wdata_i;
    end

    assign rd_bank[b] = mem_q[ptr_i];
  end

  assign rdata_o = rd_bank[bank_i];

endmodule

// File: rtl/xfr_scratch_unit.sv
module xfr_scratch_unit
  import xfr_pkg::*;
#(
  parameter  int unsigned NUM_REGS = 30,
  localparam int unsigned REG_W    = $clog2(NUM_REGS),
  localparam int unsigned LEN_W    = $clog2(NUM_REGS * 4 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [7:0]       dev_i,
  input  logic [REG_W-1:0] reg_i,
  input  logic [1:0]       lane_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             done_o,
  output logic             err_o,
  output logic [REG_W-1:0] rf_idx_o,
  output logic [1:0]       rf_lane_o,
  output logic             rf_we_o,
  output logic [7:0]       rf_wdata_o,
  input  logic [7:0]       rf_rdata_i
);

  localparam int unsigned NUM_BYTES = NUM_REGS * 4;
  localparam int unsigned PTR_W     = REG_W + 2;

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  xfr_mode_t        mode_d, mode_q;
  logic             bad;
  logic             accept;
  logic             active;
  logic [PTR_W-1:0] ptr;
  logic             bank_we;
  logic [7:0]       bank_rd;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  xfr_dev_decode #(
    .PTR_W     (PTR_W),
    .LEN_W     (LEN_W),
    .NUM_BYTES (NUM_BYTES)
  ) u_decode (
    .op_i   (xfr_op_e'(op_i)),
    .dev_i  (dev_i),
    .ptr_i  ({reg_i, lane_i}),
    .len_i  (len_i),
    .mode_o (mode_d),
    .bad_o  (bad)
  );

  xfr_cursor #(
    .PTR_W (PTR_W),
    .LEN_W (LEN_W)
  ) u_cursor (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_i  (start_i),
    .bad_i    (bad),
    .ptr_i    ({reg_i, lane_i}),
    .len_i    (len_i),
    .accept_o (accept),
    .active_o (active),
    .ptr_o    (ptr),
    .done_o   (done_o),
    .err_o    (err_o)
  );

  // Command mode held for the length of the transfer
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  mode_q <= '0;
    else if (accept) mode_q <= mode_d;
  end

  assign bank_we = active && ((mode_q.act == ACT_WRITE) || (mode_q.act == ACT_SWAP));

  xfr_bank_store #(
    .NUM_BYTES (NUM_BYTES),
    .PTR_W     (PTR_W)
  ) u_banks (
    .clk     (clk),
    .we_i    (bank_we),
    .bank_i  (mode_q.bank),
    .ptr_i   (ptr),
    .wdata_i (rf_rdata_i),
    .rdata_o (bank_rd)
  );

  assign rf_idx_o   = ptr[PTR_W-1:2];
  assign rf_lane_o  = ptr[1:0];
  assign rf_we_o    = active && (mode_q.act != ACT_WRITE);
  assign rf_wdata_o = (mode_q.act == ACT_FILL) ? mode_q.fill : bank_rd;

  assert_err_after_start_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    err_o |-> $past(accept));

  assert_quiet_on_done_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> (!rf_we_o && !bank_we));

  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rst_int_n |-> (!done_o && !err_o && !rf_we_o));

endmodule

// File: tb/xfr_scratch_unit_tb_top.sv
module xfr_scratch_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NBYTES     = 120;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [1:0] op_i;
  logic [7:0] dev_i;
  logic [4:0] reg_i;
  logic [1:0] lane_i;
  logic [6:0] len_i;
  logic       done_o, err_o, rf_we_o;
  logic [4:0] rf_idx_o;
  logic [1:0] rf_lane_o;
  logic [7:0] rf_wdata_o, rf_rdata_i;

  logic [7:0] rf      [128];
  logic [7:0] exp_rf  [128];
  logic [7:0] exp_bank[4][128];

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xfr_scratch_unit dut_i (
    .clk, .rst_n, .start_i, .op_i, .dev_i, .reg_i, .lane_i, .len_i,
    .done_o, .err_o, .rf_idx_o, .rf_lane_o, .rf_we_o, .rf_wdata_o, .rf_rdata_i
  );

  // Register file model seen by the unit
  assign rf_rdata_i = rf[{rf_idx_o, rf_lane_o}];
  always @(posedge clk) begin
    if (rf_we_o) rf[{rf_idx_o, rf_lane_o}] <= rf_wdata_o;
  end

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] dev;
    logic [4:0] rg;
    logic [1:0] ln;
    logic [6:0] len;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 8'd11,  5'd3,  2'd2, 7'd9},    // write-out across a lane wrap (R2)
    '{2'd0, 8'd10,  5'd0,  2'd0, 7'd120},  // full read-in
    '{2'd0, 8'd14,  5'd29, 2'd1, 7'd3},    // ends exactly at the last byte
    '{2'd2, 8'd12,  5'd5,  2'd3, 7'd6},    // exchange
    '{2'd0, 8'd254, 5'd7,  2'd1, 7'd5},    // fill ones
    '{2'd0, 8'd255, 5'd8,  2'd0, 7'd4},    // fill zeros
    '{2'd1, 8'd254, 5'd1,  2'd0, 7'd4},    // fill ID with write-out
    '{2'd2, 8'd255, 5'd2,  2'd0, 7'd4},    // fill ID with exchange
    '{2'd0, 8'd13,  5'd0,  2'd0, 7'd4},    // unknown device
    '{2'd3, 8'd10,  5'd0,  2'd0, 7'd4},    // reserved op
    '{2'd0, 8'd10,  5'd29, 2'd2, 7'd3},    // one byte past the end
    '{2'd1, 8'd14,  5'd0,  2'd0, 7'd0},    // zero length
    '{2'd0, 8'd11,  5'd3,  2'd0, 7'd12},   // read back the first write-out
    '{2'd2, 8'd14,  5'd10, 2'd0, 7'd8},    // exchange on the peer bank
    '{2'd0, 8'd10,  5'd31, 2'd0, 7'd0}     // start beyond the register file
  };

  function automatic int bank_of(input logic [7:0] dev);
    case (dev)
      8'd10:   return 0;
      8'd11:   return 1;
      8'd12:   return 2;
      8'd14:   return 3;
      default: return -1;
    endcase
  endfunction

  task automatic check(input bit ok, input string msg);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic compare_rf(input string req);
    int bad_at = -1;
    for (int i = 0; i < NBYTES; i++) begin
      if (bad_at < 0 && rf[i] !== exp_rf[i]) bad_at = i;
    end
    if (bad_at < 0) check(1'b1, req);
    else check(1'b0, $sformatf("%s register byte %0d: actual %02h expected %02h",
                               req, bad_at, rf[bad_at], exp_rf[bad_at]));
  endtask

  task automatic run_op(input logic [1:0] op, input logic [7:0] dev, input logic [4:0] rg,
                        input logic [1:0] ln, input logic [6:0] len, input string hint);
    int    p0, bk, k, nexp;
    bit    isfill, bad, err_seen;
    logic [7:0] tmp;
    string req;
    p0     = int'(rg) * 4 + int'(ln);
    bk     = bank_of(dev);
    isfill = (dev == 8'd254) || (dev == 8'd255);
    bad    = (op == 2'd3) || (bk < 0 && !isfill) || (isfill && op != 2'd0)
          || (p0 + int'(len) > NBYTES);
    nexp   = bad ? 0 : int'(len);
    if (hint != "")                   req = hint;
    else if (p0 + int'(len) > NBYTES) req = "R8";
    else if (bad)                     req = "R7";
    else if (len == 0)                req = "R9";
    else if (isfill)                  req = "R6";
    else if (op == 2'd0)              req = "R3";
    else if (op == 2'd1)              req = "R4";
    else                              req = "R5";

    @(negedge clk);
    start_i = 1'b1; op_i = op; dev_i = dev; reg_i = rg; lane_i = ln; len_i = len;
    @(negedge clk);
    start_i = 1'b0;
    k = 0;
    while (!done_o && k < 400) begin
      @(negedge clk);
      k++;
    end
    err_seen = err_o;
    check(k == nexp && err_seen == bad,
          $sformatf("%s/R1 done after %0d cycles err %0b, expected %0d err %0b",
                    req, k, err_seen, nexp, bad));
    @(negedge clk);
    check(done_o == 1'b0, $sformatf("R1 done pulse width: actual %0b expected 0", done_o));

    if (!bad) begin
      for (int i = 0; i < int'(len); i++) begin
        int p = p0 + i;
        case (op)
          2'd0: exp_rf[p] = isfill ? ((dev == 8'd254) ? 8'hFF : 8'h00) : exp_bank[bk][p];
          2'd1: exp_bank[bk][p] = exp_rf[p];
          default: begin
            tmp            = exp_rf[p];
            exp_rf[p]      = exp_bank[bk][p];
            exp_bank[bk][p] = tmp;
          end
        endcase
      end
    end
    compare_rf(req);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] bank_ids [4] = '{8'd10, 8'd11, 8'd12, 8'd14};
    rst_n = 1'b0; start_i = 1'b0; op_i = '0; dev_i = '0;
    reg_i = '0; lane_i = '0; len_i = '0;

    // R11: reset state
    repeat (3) @(negedge clk);
    check(!done_o && !err_o && !rf_we_o,
          $sformatf("R11 in reset: done %0b err %0b we %0b, expected 0 0 0", done_o, err_o, rf_we_o));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!done_o && !err_o && !rf_we_o,
          $sformatf("R11 after reset: done %0b err %0b we %0b, expected 0 0 0", done_o, err_o, rf_we_o));

    // Fill every bank with its own pattern through full write-outs (R4)
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < 128; i++) begin
        rf[i]     = 8'((i * 7) + (b * 53) + 1);
        exp_rf[i] = rf[i];
      end
      run_op(2'd1, bank_ids[b], 5'd0, 2'd0, 7'd120, "R4");
    end

    // Main table, with register contents reseeded first
    for (int i = 0; i < 128; i++) begin
      rf[i]     = 8'((i * 29) ^ 8'h5A);
      exp_rf[i] = rf[i];
    end
    for (int v = 0; v < NVEC; v++) begin
      run_op(VECS[v].op, VECS[v].dev, VECS[v].rg, VECS[v].ln, VECS[v].len, "");
    end

    // R10: start during a running transfer is ignored
    begin
      int k;
      @(negedge clk);
      start_i = 1'b1; op_i = 2'd0; dev_i = 8'd12; reg_i = 5'd2; lane_i = 2'd0; len_i = 7'd8;
      @(negedge clk);
      start_i = 1'b0;
      k = 0;
      while (!done_o && k < 400) begin
        @(negedge clk);
        k++;
        if (k == 2) begin
          start_i = 1'b1; op_i = 2'd1; dev_i = 8'd10; reg_i = 5'd0; lane_i = 2'd0; len_i = 7'd120;
        end else begin
          start_i = 1'b0;
        end
      end
      check(k == 8 && !err_o,
            $sformatf("R10 done after %0d cycles err %0b, expected 8 err 0", k, err_o));
      repeat (3) @(negedge clk);
      check(!done_o && !rf_we_o,
            $sformatf("R10 second transfer ran: done %0b we %0b, expected 0 0", done_o, rf_we_o));
      for (int i = 8; i < 16; i++) exp_rf[i] = exp_bank[2][i];
      compare_rf("R10");
    end

    // R12: every bank read back in full
    for (int b = 0; b < 4; b++) begin
      run_op(2'd0, bank_ids[b], 5'd0, 2'd0, 7'd120, "R12");
    end

    finish_run();
  end

endmodule